// File: doc/BRIEF.md
# Write Completion Status Responder

This block owns the 8-bit read bus of a page-programmed non-volatile memory. While the array is idle, it returns the addressed array byte. While an internal programming cycle runs, it returns progress status in place of array data. A host can use either of two end-of-write checks on the same bus. In the first, it reads the byte it wrote last and waits until bit 7 stops reading back inverted. In the second, it reads any location repeatedly and waits until bit 6 stops changing from one read to the next.

Status is shown in two cases. The first is a real programming cycle, flagged by `prog_busy`. The second is a blocked write aimed at a protected device, signalled by a one-cycle `blk_start` pulse. A blocked write stores nothing, but it still shows status for a fixed window of `WC_CYCLES` clocks. All pins are sampled on `clk`, and the bus is modelled as a registered value `dq_out` plus an enable `dq_oe`. Both follow the sampled strobes with one cycle of latency.

The controller has three states:
- `ST_READY`: no write activity.
- `ST_PROG`: programming in progress.
- `ST_GUARD`: blocked-write window.

It has five named transitions:
- `T_START_PROG`: READY to PROG, taken while `prog_busy` is high.
- `T_START_GUARD`: READY to GUARD, taken on a `blk_start` pulse.
- `T_PROG_DONE`: PROG to READY, taken when `prog_busy` falls.
- `T_GUARD_DONE`: GUARD to READY, taken when the window counter reaches `WC_CYCLES-1`.
- `T_GUARD_TO_PROG`: GUARD to PROG, taken if `prog_busy` rises during the window.

"Busy" means any state other than `ST_READY`.

Top module: `wcs_responder`

## Requirements
- R1: A read is active when `ce_n`=0, `oe_n`=0 and `we_n`=1 at a clock edge. At the next cycle `dq_oe` is 1.
- R2: If `ce_n`=1, `oe_n`=1 or `we_n`=0 at an edge, then `dq_oe` is 0 and `dq_out` is 0 in the next cycle.
- R3: A read sampled while not busy returns `arr_data` on all eight bits.
- R4: A busy read with `rd_addr`==`last_addr` puts the inverse of `last_data[7]` on bit 7. A busy read at any other address puts `arr_data[7]` on bit 7.
- R5: Each new read during busy inverts bit 6 relative to the previous read. A read is new when the read condition of R1 was false on the previous edge, so toggling `oe_n`, `ce_n` or both each counts as one read.
- R6: A read held across several edges is not a new read, so bit 6 keeps its value.
- R7: During busy, bits 5:0 return `last_data[5:0]`. The toggle bit starts from `last_data[6]` when busy begins, so the first new read shows its inverse. A held read that was already active when busy began shows `last_data[6]`.
- R8: Once `prog_busy` falls, the next read returns true array data, and bit 6 no longer changes between reads.
- R9: A `blk_start` pulse sampled in `ST_READY` makes reads sampled on the following `WC_CYCLES` edges status reads. The read after that returns array data.
- R10: During reset the bus floats (`dq_oe`=0, `dq_out`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_busy | input | 1 | Internal programming cycle active |
| blk_start | input | 1 | One-cycle pulse: write blocked by protection |
| last_addr | input | AW | Address of the last byte written |
| last_data | input | DW | Value of the last byte written |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | AW | Read address |
| arr_data | input | DW | Array byte at `rd_addr` |
| dq_out | output | DW | Read bus data |
| dq_oe | output | 1 | Read bus drive enable |

## Verification
Two kinds of internal fault show up at the ports, each within one cycle.
- A wrong controller state returns array data where status belongs, or the reverse. This appears on the first read after the fault, so each boundary of busy is probed with a read on each side of it, including the exact last cycle of the blocked-write window.
- A wrong toggle register changes bit 6 when a read is merely held, or fails to change it on a new read. Pairs of consecutive reads (through `oe_n`, through `ce_n`, and held) compare bit 6 directly.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_PROG  = 2'd1,
        ST_GUARD = 2'd2
    } wcs_state_e;
endpackage

// File: rtl/wcs_fsm.sv
module wcs_fsm
    import wcs_pkg::*;
#(
    parameter int WC_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_busy,
    input  logic       blk_start,
    output wcs_state_e state,
    output logic       busy
);
    localparam int TW = $clog2(WC_CYCLES + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(WC_CYCLES - 1);

    wcs_state_e      state_q, state_d;
    logic [TW-1:0]   timer_q, timer_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    // next state and window counter
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            ST_READY: begin
                timer_d = '0;
                if (prog_busy) begin
                    state_d = ST_PROG;           // T_START_PROG
                end else if (blk_start) begin
                    state_d = ST_GUARD;          // T_START_GUARD
                end
            end
            ST_PROG: begin
                timer_d = '0;
                if (!prog_busy) begin
                    state_d = ST_READY;          // T_PROG_DONE
                end
            end
            ST_GUARD: begin
                if (prog_busy) begin
                    state_d = ST_PROG;           // T_GUARD_TO_PROG
                    timer_d = '0;
                end else if (timer_q == LAST_TICK) begin
                    state_d = ST_READY;          // T_GUARD_DONE
                    timer_d = '0;
                end else begin
                    timer_d = timer_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_READY;
                timer_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        state = state_q;
        busy  = (state_q != ST_READY);
    end
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_start,
    input  logic seed,
    output logic tgl_nxt,
    output logic tgl_q
);
    always_comb begin
        if (!busy) begin
            tgl_nxt = seed;
        end else if (rd_start) begin
            tgl_nxt = ~tgl_q;
        end else begin
            tgl_nxt = tgl_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else begin
            tgl_q <= tgl_nxt;
        end
    end
endmodule

// File: rtl/wcs_readmux.sv
module wcs_readmux #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  logic          busy,
    input  logic          addr_hit,
    input  logic          tgl_nxt,
    input  logic [DW-1:0] last_data,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    localparam int POLL_BIT = DW - 1;
    localparam int TGL_BIT  = DW - 2;

    logic [DW-1:0] status_w;
    logic [DW-1:0] value_w;

    always_comb begin
        status_w           = last_data;
        status_w[POLL_BIT] = addr_hit ? ~last_data[POLL_BIT] : arr_data[POLL_BIT];
        status_w[TGL_BIT]  = tgl_nxt;
        value_w            = busy ? status_w : arr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            dq_oe  <= rd_act;
            dq_out <= rd_act ? value_w : '0;
        end
    end
endmodule

// File: rtl/wcs_responder.sv
module wcs_responder
    import wcs_pkg::*;
#(
    parameter int AW        = 15,
    parameter int DW        = 8,
    parameter int WC_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_busy,
    input  logic          blk_start,
    input  logic [AW-1:0] last_addr,
    input  logic [DW-1:0] last_data,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    localparam int TGL_BIT = DW - 2;

    wcs_state_e state;
    logic       busy;
    logic       rd_act, rd_act_q, rd_start;
    logic       addr_hit;
    logic       tgl_nxt, tgl_q;

    always_comb begin
        rd_act   = !ce_n && !oe_n && we_n;
        rd_start = rd_act && !rd_act_q;
        addr_hit = (rd_addr == last_addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
        end
    end

    wcs_fsm #(.WC_CYCLES(WC_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_busy (prog_busy),
        .blk_start (blk_start),
        .state     (state),
        .busy      (busy)
    );

    wcs_toggle u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .rd_start (rd_start),
        .seed     (last_data[TGL_BIT]),
        .tgl_nxt  (tgl_nxt),
        .tgl_q    (tgl_q)
    );

    wcs_readmux #(.DW(DW)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_act    (rd_act),
        .busy      (busy),
        .addr_hit  (addr_hit),
        .tgl_nxt   (tgl_nxt),
        .last_data (last_data),
        .arr_data  (arr_data),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );
endmodule

// File: rtl/wcs_responder_chk.sv
module wcs_responder_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rd_act,
    input logic          rd_start,
    input logic          addr_hit,
    input logic          tgl_q,
    input logic [DW-1:0] last_data,
    input logic [DW-1:0] arr_data,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe
);
    p_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> dq_oe);

    p_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> (!dq_oe && dq_out == '0));

    p_true_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_act) |=> dq_out == $past(arr_data));

    p_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_act && addr_hit) |=> dq_out[DW-1] == ~$past(last_data[DW-1]));

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_start) |=> tgl_q != $past(tgl_q));

    p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_act) |=> dq_out[DW-3:0] == $past(last_data[DW-3:0]));
endmodule

bind wcs_responder wcs_responder_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_act    (rd_act),
    .rd_start  (rd_start),
    .addr_hit  (addr_hit),
    .tgl_q     (tgl_q),
    .last_data (last_data),
    .arr_data  (arr_data),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
);

// File: tb/wcs_responder_tb.sv
module wcs_responder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int WC = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_busy = 1'b0;
    logic          blk_start = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_data = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wcs_responder #(.AW(AW), .DW(DW), .WC_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .blk_start(blk_start),
        .last_addr(last_addr), .last_data(last_data), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .rd_addr(rd_addr), .arr_data(arr_data),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        check("R10 reset", {dq_oe, dq_out}, 9'h000);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R10 idle after reset", {dq_oe, dq_out}, 9'h000);
    endtask

    task automatic t_idle_read();
        rd_addr = 15'h0040; arr_data = 8'hA5;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        tick();
        check("R1 R3 idle read", {dq_oe, dq_out}, {1'b1, 8'hA5});
        arr_data = 8'h5A; rd_addr = 15'h0041;
        tick();
        check("R3 idle read new addr", {dq_oe, dq_out}, {1'b1, 8'h5A});
    endtask

    task automatic t_float();
        oe_n = 1'b1;
        tick();
        check("R2 oe high floats", {dq_oe, dq_out}, 9'h000);
        oe_n = 1'b0; we_n = 1'b0;
        tick();
        check("R2 we low floats", {dq_oe, dq_out}, 9'h000);
        we_n = 1'b1; ce_n = 1'b1;
        tick();
        check("R2 ce high floats", {dq_oe, dq_out}, 9'h000);
        oe_n = 1'b1;
    endtask

    task automatic t_program_status();
        last_addr = 15'h1234; last_data = 8'h3C;
        rd_addr = 15'h1234; arr_data = 8'h55;
        ce_n = 1'b0; oe_n = 1'b1;
        prog_busy = 1'b1;
        tick();
        oe_n = 1'b0;
        tick();
        check("R4 R5 R7 first poll", {dq_oe, dq_out}, {1'b1, 8'hFC});
        tick();
        check("R6 held read keeps bit6", {dq_oe, dq_out}, {1'b1, 8'hFC});
        oe_n = 1'b1;
        tick();
        oe_n = 1'b0;
        tick();
        check("R5 oe toggle flips bit6", {dq_oe, dq_out}, {1'b1, 8'hBC});
        ce_n = 1'b1;
        tick();
        ce_n = 1'b0;
        tick();
        check("R5 ce toggle flips bit6", {dq_oe, dq_out}, {1'b1, 8'hFC});
        oe_n = 1'b1;
        rd_addr = 15'h0001;
        tick();
        oe_n = 1'b0;
        tick();
        check("R4 nonmatch bit7 from array", {dq_oe, dq_out}, {1'b1, 8'h3C});
    endtask

    task automatic t_complete();
        oe_n = 1'b1;
        prog_busy = 1'b0;
        tick();
        rd_addr = 15'h1234; arr_data = 8'h55;
        oe_n = 1'b0;
        tick();
        check("R8 true data after done", {dq_oe, dq_out}, {1'b1, 8'h55});
        oe_n = 1'b1;
        tick();
        oe_n = 1'b0;
        tick();
        check("R8 bit6 stops toggling", {dq_oe, dq_out}, {1'b1, 8'h55});
    endtask

    task automatic t_blocked();
        last_addr = 15'h0200; last_data = 8'h81;
        rd_addr = 15'h0200; arr_data = 8'h00;
        ce_n = 1'b0; oe_n = 1'b0;
        tick();
        check("R3 array before blocked", {dq_oe, dq_out}, {1'b1, 8'h00});
        blk_start = 1'b1;
        tick();
        blk_start = 1'b0;
        check("R9 edge of pulse still array", {dq_oe, dq_out}, {1'b1, 8'h00});
        tick();
        check("R9 R7 first guarded read", {dq_oe, dq_out}, {1'b1, 8'h01});
        for (int i = 1; i < WC; i++) tick();
        check("R9 last guarded read", {dq_oe, dq_out}, {1'b1, 8'h01});
        tick();
        check("R9 array after window", {dq_oe, dq_out}, {1'b1, 8'h00});
        oe_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_idle_read();
        t_float();
        t_program_status();
        t_complete();
        t_blocked();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule